// File: doc/BRIEF.md
# Dual-Clock Compensated 64-bit Timer

This block keeps a 64-bit time base counted in units of a fast reference tick, and keeps that base continuous while the system runs from a slow 32.768 kHz clock. Both clocks are modelled as single-cycle enables (`fast_tick`, `slow_tick`) inside one clock domain. The `on_slow` input tells the block that the fast reference is gone. While `on_slow` is high, fast ticks are not counted.

There are two ways to bridge the time spent on the slow clock. In hard-adjust mode the hardware counts slow ticks in groups of a programmed denominator. It adds a programmed numerator for each complete group. At reset these are 64 and 46875, the reduced ratio of 24 MHz to 32.768 kHz. In soft-adjust mode software writes a 64-bit delta and raises a sync request. The delta is added at the next slow tick. The block timestamps the counter when the system enters and leaves the slow clock, so software can work out the delta.

Software reaches the block through a simple 32-bit register port with word addresses. Writes take effect on the clock edge. Reads are combinational. Reading the low word of a live counter latches its high word, so a later high-word read returns the matching upper half.

Top module: `hp_timer`

## Requirements
- R1: After reset the register values are as follows. Control (addr 0) is 0, interrupt enable (1) is 0 and status (2) is 0. Numerator (3) reads 46875 and denominator (4) reads 64. Load low and high (5, 6) read 0xFFFFFFFF. Current value (10, 11) reads 0, valid (18) reads 0, and `irq` is low.
- R2: While control bit 0 (enable) is 0, the counter holds its value whatever the tick inputs do.
- R3: The control mode field is bits 2:1: 0 is normal, 1 is hard adjust, 2 is soft adjust. When enabled, in every mode, each `fast_tick` with `on_slow` low adds 1 to the counter. Fast ticks while `on_slow` is high add nothing.
- R4: Reading the current low word (addr 10) latches the upper half. A later read of addr 11 returns that latched half even if the counter has moved. The same rule applies to the slow count at addr 12 and 13.
- R5: In hard-adjust mode with `on_slow` high, slow ticks are counted in groups. Each group is the denominator in length, and a denominator of 0 acts as 1. Each completed group adds the numerator to the counter and sets status bit 1. The group restarts whenever `on_slow` is low or the mode is not hard adjust.
- R6: Writing 1 to sync request (addr 9) arms a pending add. At the next `slow_tick` while enabled, the 64-bit delta (low word at addr 7, high word at addr 8) is added to the counter and status bit 2 is set. The counter does not change before that tick.
- R7: Writing to the status register clears exactly the bits that are written as 1. Writing 0x7 clears all three bits. A bit that is being set in the same cycle stays set.
- R8: A fast tick and a pending delta that land in the same cycle both take effect: the counter gains delta + 1.
- R9: Status bit 0 is set while the block is enabled and the counter equals the 64-bit load value.
- R10: With control bit 3 (count mode) set, an enabled counter that equals the load value restarts at 0 on the next edge.
- R11: A rising edge of `on_slow` captures the counter into the begin timestamp (addr 14, 15) and sets valid bit 0. A falling edge captures the counter into the end timestamp (addr 16, 17) and sets valid bit 1. Writing 1 to a valid bit clears it.
- R12: Every `slow_tick` while enabled adds 1 to the 64-bit slow count (addr 12, 13).
- R13: `irq` is high exactly when some status bit and its enable bit in the interrupt enable register (addr 1) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | One-cycle enable marking a fast reference tick |
| slow_tick | input | 1 | One-cycle enable marking a 32.768 kHz tick |
| on_slow | input | 1 | High while the system runs from the slow clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives high-word latching) |
| addr | input | 5 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Interrupt request, status masked by enables |

## Verification
A pending sync delta and a fast tick can fall in the same cycle. In that cycle the adder sees two addends at once. The bench provokes this by arming the sync request in soft mode, then raising `fast_tick` and `slow_tick` together on one edge. It reads the counter back and judges the result against the earlier value plus delta plus one. A status bit being set while software clears it is the second collision: the bench checks that a clear of other bits leaves the set bit intact.

// File: rtl/hp_timer.sv
module hp_timer #(
  parameter int DW      = 32,
  parameter int AW      = 5,
  parameter int NUM_RST = 46875,
  parameter int DEN_RST = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fast_tick,
  input  logic          slow_tick,
  input  logic          on_slow,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 2 * DW;
  localparam logic [1:0] MODE_HARD = 2'd1;
  localparam logic [AW-1:0] A_CTRL = 0, A_IE = 1, A_STAT = 2, A_NUM = 3, A_DEN = 4,
    A_LDL = 5, A_LDH = 6, A_DLL = 7, A_DLH = 8, A_SYNC = 9, A_CURL = 10, A_CURH = 11,
    A_SLL = 12, A_SLH = 13, A_BGL = 14, A_BGH = 15, A_ENL = 16, A_ENH = 17, A_VLD = 18;

  logic [3:0]    ctrl;
  logic [2:0]    ie, stat;
  logic [1:0]    vld;
  logic [DW-1:0] num, den, grp, cur_hi, slow_hi;
  logic [CW-1:0] load, delta, cnt, slow_cnt, beg_ts, end_ts;
  logic          pend, on_slow_q;

  wire en      = ctrl[0];
  wire restart = ctrl[3];
  wire hard_on = en && ctrl[2:1] == MODE_HARD && on_slow;
  wire [DW:0] grp_inc = {1'b0, grp} + 1'b1;
  wire grp_done = hard_on && slow_tick && (grp_inc >= {1'b0, den});
  wire fast_inc = en && fast_tick && !on_slow;
  wire sync_go  = en && pend && slow_tick;
  wire hit      = en && cnt == load;
  wire rise     = on_slow && !on_slow_q;
  wire fall     = !on_slow && on_slow_q;
  wire sync_wr  = wr_en && addr == A_SYNC && wdata[0];

  wire [CW-1:0] cnt_sum = cnt + {{(CW-1){1'b0}}, fast_inc}
                        + (grp_done ? {{DW{1'b0}}, num} : '0)
                        + (sync_go ? delta : '0);

  wire [2:0] stat_clr = (wr_en && addr == A_STAT) ? wdata[2:0] : 3'b0;
  wire [1:0] vld_clr  = (wr_en && addr == A_VLD) ? wdata[1:0] : 2'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; ie <= '0; num <= DW'(NUM_RST); den <= DW'(DEN_RST);
      load <= '1; delta <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: ctrl <= wdata[3:0];
        A_IE:   ie <= wdata[2:0];
        A_NUM:  num <= wdata;
        A_DEN:  den <= wdata;
        A_LDL:  load[DW-1:0] <= wdata;
        A_LDH:  load[CW-1:DW] <= wdata;
        A_DLL:  delta[DW-1:0] <= wdata;
        A_DLH:  delta[CW-1:DW] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; slow_cnt <= '0; grp <= '0; pend <= 1'b0; on_slow_q <= 1'b0;
      stat <= '0; vld <= '0; beg_ts <= '0; end_ts <= '0;
    end else begin
      cnt <= (hit && restart) ? '0 : cnt_sum;
      if (en && slow_tick) slow_cnt <= slow_cnt + 1'b1;
      if (!hard_on) grp <= '0;
      else if (slow_tick) grp <= grp_done ? '0 : grp_inc[DW-1:0];
      if (sync_wr) pend <= 1'b1;
      else if (sync_go) pend <= 1'b0;
      on_slow_q <= on_slow;
      stat <= (stat & ~stat_clr) | {sync_go, grp_done, hit};
      vld  <= (vld & ~vld_clr) | {fall, rise};
      if (rise) beg_ts <= cnt;
      if (fall) end_ts <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_hi <= '0; slow_hi <= '0;
    end else if (rd_en) begin
      if (addr == A_CURL) cur_hi <= cnt[CW-1:DW];
      if (addr == A_SLL)  slow_hi <= slow_cnt[CW-1:DW];
    end
  end

  always_comb begin
    case (addr)
      A_CTRL: rdata = {{(DW-4){1'b0}}, ctrl};
      A_IE:   rdata = {{(DW-3){1'b0}}, ie};
      A_STAT: rdata = {{(DW-3){1'b0}}, stat};
      A_NUM:  rdata = num;
      A_DEN:  rdata = den;
      A_LDL:  rdata = load[DW-1:0];
      A_LDH:  rdata = load[CW-1:DW];
      A_DLL:  rdata = delta[DW-1:0];
      A_DLH:  rdata = delta[CW-1:DW];
      A_SYNC: rdata = {{(DW-1){1'b0}}, pend};
      A_CURL: rdata = cnt[DW-1:0];
      A_CURH: rdata = cur_hi;
      A_SLL:  rdata = slow_cnt[DW-1:0];
      A_SLH:  rdata = slow_hi;
      A_BGL:  rdata = beg_ts[DW-1:0];
      A_BGH:  rdata = beg_ts[CW-1:DW];
      A_ENL:  rdata = end_ts[DW-1:0];
      A_ENH:  rdata = end_ts[CW-1:DW];
      A_VLD:  rdata = {{(DW-2){1'b0}}, vld};
      default: rdata = '0;
    endcase
  end

  assign irq = |(stat & ie);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == $past(cnt));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart && cnt == load) |=> cnt == '0);
  assert_sync_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en && slow_tick) |=> stat[2]);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[2] && !(wr_en && addr == A_STAT && wdata[2])) |=> stat[2]);
  assert_begin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (on_slow && !on_slow_q) |=> (vld[0] && beg_ts == $past(cnt)));
  assert_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && ctrl[2:1] == MODE_HARD && on_slow) |=> grp == '0);
endmodule

// File: tb/hp_timer_tb_top.sv
`timescale 1ns/1ps
module hp_timer_tb_top;
  logic clk = 0, rst_n = 0, fast_tick = 0, slow_tick = 0, on_slow = 0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hp_timer dut_i (.clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .on_slow(on_slow), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  localparam logic [31:0] T_NUM [6] = '{46875, 46875, 5, 1, 100, 7};
  localparam logic [31:0] T_DEN [6] = '{64, 64, 3, 1, 2, 0};
  localparam int          T_TCK [6] = '{64, 130, 7, 4, 1, 3};
  localparam logic [63:0] T_EXP [6] = '{46875, 93750, 10, 4, 0, 21};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd64(logic [4:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 5'd1, hi); v = {hi, lo};
  endtask

  task automatic fpulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fast_tick = 1; @(negedge clk); fast_tick = 0;
    end
  endtask

  task automatic spulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1; @(negedge clk); slow_tick = 0;
    end
  endtask

  task automatic set_delta(logic [63:0] d);
    wr(7, d[31:0]); wr(8, d[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, h0;
    logic [63:0] a, b;
    repeat (3) @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(0, r); chk("R1 ctrl", r, 0);
    rd(2, r); chk("R1 status", r, 0);
    rd(3, r); chk("R1 numerator", r, 46875);
    rd(4, r); chk("R1 denominator", r, 64);
    rd64(5, a); chk("R1 load", a, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(10, a); chk("R1 current", a, 0);
    rd(18, r); chk("R1 valid", r, 0);
    chk("R1 irq", irq, 0);

    // R2 disabled holds
    fpulse(5); spulse(2); rd64(10, a); chk("R2 hold", a, 0);

    // R3 normal counting, ignored on slow clock
    wr(0, 1); fpulse(10); rd64(10, a); chk("R3 fast count", a, 10);
    on_slow = 1; fpulse(4); on_slow = 0; @(negedge clk);
    rd64(10, a); chk("R3 ignored on slow", a, 10);

    // R5 hard adjust table
    for (int k = 0; k < 6; k++) begin
      wr(0, 1); wr(2, 7);
      wr(3, T_NUM[k]); wr(4, T_DEN[k]);
      rd64(10, a);
      wr(0, 3); on_slow = 1; @(negedge clk);
      spulse(T_TCK[k]);
      on_slow = 0; @(negedge clk);
      rd64(10, b); chk("R5 hard step", b - a, T_EXP[k]);
      rd(2, r); chk("R5 adjust done", r[1], T_EXP[k] != 0);
    end

    // R6 soft adjust delta
    wr(0, 5); wr(2, 7); rd64(10, a);
    set_delta(64'h1_0000_0003); wr(9, 1);
    fpulse(0); @(negedge clk);
    rd64(10, b); chk("R6 no add before slow tick", b, a);
    spulse(1); rd64(10, b); chk("R6 delta added", b, a + 64'h1_0000_0003);
    rd(2, r); chk("R6 sync done", r[2], 1);

    // R7 write-one-to-clear
    wr(2, 3); rd(2, r); chk("R7 other bits keep bit2", r[2], 1);
    wr(2, 4); rd(2, r); chk("R7 bit2 cleared", r[2], 0);

    // R4 coherent read
    rd(10, r); rd(10, r);
    set_delta(64'h1_0000_0000); wr(9, 1); spulse(1);
    rd(10, r); h0 = 0;
    rd(11, h0);
    rd64(10, a);
    chk("R4 high matches latched", h0, a[63:32]);
    rd(10, r); set_delta(64'h1_0000_0000); wr(9, 1); spulse(1);
    rd(11, h0); chk("R4 stale high kept", h0, a[63:32]);
    rd64(10, b); chk("R4 new high after low", b[63:32], a[63:32] + 1);

    // R8 sync add and fast tick in one cycle
    rd64(10, a); set_delta(64'd1000); wr(9, 1);
    @(negedge clk); fast_tick = 1; slow_tick = 1;
    @(negedge clk); fast_tick = 0; slow_tick = 0;
    rd64(10, b); chk("R8 same cycle sum", b, a + 64'd1001);

    // R9 reached
    wr(0, 1); wr(2, 7); rd64(10, a); a = a + 5;
    wr(6, a[63:32]); wr(5, a[31:0]);
    fpulse(5); rd(2, r); chk("R9 reached", r[0], 1);

    // R13 irq masking
    wr(1, 0); chk("R13 masked", irq, 0);
    wr(1, 1); @(negedge clk); chk("R13 raised", irq, 1);
    wr(1, 0);

    // R10 restart
    fpulse(1); wr(2, 7); rd64(10, a); a = a + 3;
    wr(6, a[63:32]); wr(5, a[31:0]); wr(0, 9);
    fpulse(3); rd64(10, b); chk("R10 restart to zero", b, 0);
    wr(0, 1);

    // R11 timestamps
    wr(18, 3); rd64(10, a);
    on_slow = 1; repeat (2) @(negedge clk);
    rd(18, r); chk("R11 begin valid", r, 1);
    rd64(14, b); chk("R11 begin value", b, a);
    on_slow = 0; repeat (2) @(negedge clk);
    rd(18, r); chk("R11 both valid", r, 3);
    rd64(16, b); chk("R11 end value", b, a);
    wr(18, 3); rd(18, r); chk("R11 valid cleared", r, 0);

    // R12 slow count
    rd64(12, a); spulse(4); rd64(12, b); chk("R12 slow count", b - a, 4);
    wr(0, 0); spulse(3); rd64(12, a); chk("R12 hold when disabled", a, b + 4 - 4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule